// File: doc/BRIEF.md
# Adaptive Thread Selector with Runahead Permit

This block decides, once per scheduling slot, which hardware thread of a multithreaded core may issue next. It also tells the pipeline whether that thread runs normally or speculatively in runahead mode. For every thread it holds a priority set by hardware and a saturating estimate of how often that thread's runahead prefetches turn out useful. The score of a thread is its priority multiplied by its accuracy.

A two-bit policy input picks one of three selection rules:
- best-score selection, with a rotating pointer to break ties;
- weighted random selection, driven by a 16-bit LFSR, where each thread's chance follows its score;
- a rule that serves ready threads before any runahead candidate.

A thread that is stalled may only be picked for runahead when its accuracy reaches a programmable threshold. The chosen grant is registered and moves forward only on cycles where the advance input is high.

Top module: `thread_selector`

## Requirements
- R1: After synchronous reset, grant is all zero, the index is 0 and the permit is 0. Every accuracy starts at 128, every priority at 1, the threshold at 128, the rotating pointer at thread 0 and the LFSR at 0xACE1.
- R2: A thread's accuracy rises by 1 when its used strobe is high alone, saturating at 255. It falls by 1 when its wasted strobe is high alone, saturating at 0. It is unchanged when both or neither are high. The update happens every cycle, whether or not advance is high.
- R3: A thread is eligible when it is ready, or when it is stalled, not ready and its accuracy is at or above the threshold (a runahead candidate). When no thread passes the selection rule, the next grant is all zero with index 0.
- R4: The permit output is 1 exactly when the granted thread was a runahead candidate, that is, not ready.
- R5: Policy code 0, and also code 3, grants the eligible thread with the largest score, score = priority × accuracy. On a tie, the winner is the first tied thread found scanning upward from the rotating pointer, wrapping around.
- R6: After a registered grant to thread k, the rotating pointer becomes (k+1) mod 4. It is unchanged when no thread is granted.
- R7: Policy code 1 grants by weighted draw. Let S be the sum of the eligible scores and L the LFSR value. The draw is floor(L×S / 65536). Each eligible thread owns a range of length equal to its score; ranges are laid out in ascending thread order. The thread whose range holds the draw wins. When S is 0, the R5 rule applies.
- R8: On each cycle with advance high, the LFSR shifts left by one bit. The new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R9: Policy code 2 applies the R5 rule among the ready threads only. If no thread is ready, it applies the R5 rule among the runahead candidates.
- R10: With advance low, grant, index and permit hold their values, and neither the pointer nor the LFSR moves.
- R11: A priority write loads the 3-bit value into the addressed thread's priority. A threshold write loads the 8-bit threshold. Both take effect for selections from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance_i | input | 1 | Register a new selection this cycle |
| policy_i | input | 2 | 0 best score, 1 weighted draw, 2 ready first, 3 best score |
| ready_i | input | 4 | Thread may issue normally |
| stalled_i | input | 4 | Thread is blocked on a long-latency miss |
| pf_used_i | input | 4 | A runahead prefetch of the thread was used |
| pf_wasted_i | input | 4 | A runahead prefetch of the thread was evicted unused |
| prio_we_i | input | 1 | Priority write strobe |
| prio_sel_i | input | 2 | Thread addressed by the priority write |
| prio_val_i | input | 3 | Priority value to load |
| thresh_we_i | input | 1 | Threshold write strobe |
| thresh_val_i | input | 8 | Threshold value to load |
| grant_o | output | 4 | One-hot registered grant, zero when none |
| grant_idx_o | output | 2 | Index of the granted thread |
| ra_permit_o | output | 1 | Granted thread runs in runahead mode |

## Verification
The bench builds the selector with its default parameters:
- 4 threads;
- 3-bit priorities;
- 8-bit accuracies starting at 128.

With these values, about 130 one-sided strobes drive a counter into either rail, so both saturation limits are reached within a short directed phase. Tie-breaking through every pointer position is reachable with equal scores. Random priority writes of zero make the all-zero score sum, and so the fallback of the weighted policy, a frequent case. All four policy codes, including the spare code, are mixed with random stall, strobe and advance patterns.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        POL_BEST         = 2'd0,
        POL_WEIGHTED     = 2'd1,
        POL_NORMAL_FIRST = 2'd2,
        POL_BEST_ALT     = 2'd3
    } policy_e;

    typedef struct packed {
        logic eligible;
        logic runahead;
    } thr_flags_t;

    // Fibonacci shift, taps 16,14,13,11
    function automatic lfsr_t lfsr_step(lfsr_t v);
        return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/tsel_acc_track.sv
module tsel_acc_track #(
    parameter int ACC_W    = 8,
    parameter int ACC_INIT = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             used_i,
    input  logic             wasted_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] TOP_V  = '1;
    localparam logic [ACC_W-1:0] INIT_V = ACC_W'(ACC_INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= INIT_V;
        end else if (used_i && !wasted_i && acc_o != TOP_V) begin
            acc_o <= acc_o + 1'b1;
        end else if (wasted_i && !used_i && acc_o != '0) begin
            acc_o <= acc_o - 1'b1;
        end
    end
endmodule

// File: rtl/tsel_prio_bank.sv
module tsel_prio_bank #(
    parameter int NT        = 4,
    parameter int PRIO_W    = 3,
    parameter int PRIO_INIT = 1,
    parameter int IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           sel_i,
    input  logic [PRIO_W-1:0]          val_i,
    output logic [NT-1:0][PRIO_W-1:0]  prio_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) prio_o[t] <= PRIO_W'(PRIO_INIT);
        end else if (we_i) begin
            for (int t = 0; t < NT; t++) begin
                if (sel_i == IDX_W'(t)) prio_o[t] <= val_i;
            end
        end
    end
endmodule

// File: rtl/tsel_lfsr.sv
module tsel_lfsr
    import tsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_i,
    output lfsr_t value_o
);
    always_ff @(posedge clk) begin
        if (rst)         value_o <= LFSR_SEED;
        else if (step_i) value_o <= lfsr_step(value_o);
    end
endmodule

// File: rtl/tsel_best_pick.sv
module tsel_best_pick #(
    parameter int NT      = 4,
    parameter int SCORE_W = 11,
    parameter int IDX_W   = 2
) (
    input  logic [NT-1:0]              mask_i,
    input  logic [NT-1:0][SCORE_W-1:0] score_i,
    input  logic [IDX_W-1:0]           rr_i,
    output logic                       found_o,
    output logic [IDX_W-1:0]           idx_o
);
    logic [SCORE_W-1:0] best;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int o = 0; o < NT; o++) begin
            int t;
            t = (int'(rr_i) + o) % NT;
            if (mask_i[t] && (!found_o || score_i[t] > best)) begin
                found_o = 1'b1;
                best    = score_i[t];
                idx_o   = IDX_W'(t);
            end
        end
    end
endmodule

// File: rtl/thread_selector.sv
module thread_selector
    import tsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int PRIO_W      = 3,
    parameter int ACC_W       = 8,
    parameter int ACC_INIT    = 128,
    parameter int THRESH_INIT = 128,
    parameter int PRIO_INIT   = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           advance_i,
    input  logic [1:0]                     policy_i,
    input  logic [NUM_THREADS-1:0]         ready_i,
    input  logic [NUM_THREADS-1:0]         stalled_i,
    input  logic [NUM_THREADS-1:0]         pf_used_i,
    input  logic [NUM_THREADS-1:0]         pf_wasted_i,
    input  logic                           prio_we_i,
    input  logic [$clog2(NUM_THREADS)-1:0] prio_sel_i,
    input  logic [PRIO_W-1:0]              prio_val_i,
    input  logic                           thresh_we_i,
    input  logic [ACC_W-1:0]               thresh_val_i,
    output logic [NUM_THREADS-1:0]         grant_o,
    output logic [$clog2(NUM_THREADS)-1:0] grant_idx_o,
    output logic                           ra_permit_o
);
    localparam int IDX_W   = $clog2(NUM_THREADS);
    localparam int SCORE_W = PRIO_W + ACC_W;
    localparam int SUM_W   = SCORE_W + IDX_W + 1;
    localparam int PROD_W  = SUM_W + LFSR_W;

    // per-thread state
    logic [NUM_THREADS-1:0][ACC_W-1:0]   acc_w;
    logic [NUM_THREADS-1:0][PRIO_W-1:0]  prio_w;
    logic [NUM_THREADS-1:0][SCORE_W-1:0] score_w;
    thr_flags_t [NUM_THREADS-1:0]        flags;
    logic [NUM_THREADS-1:0]              elig;
    logic [NUM_THREADS-1:0]              ra_cand;

    logic [ACC_W-1:0] thresh_q;
    logic [IDX_W-1:0] rr_q;
    lfsr_t            lfsr_q;
    policy_e          pol;

    generate
        for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
            tsel_acc_track #(
                .ACC_W    (ACC_W),
                .ACC_INIT (ACC_INIT)
            ) u_acc (
                .clk      (clk),
                .rst      (rst),
                .used_i   (pf_used_i[g]),
                .wasted_i (pf_wasted_i[g]),
                .acc_o    (acc_w[g])
            );

            assign flags[g].runahead = stalled_i[g] && !ready_i[g] && (acc_w[g] >= thresh_q);
            assign flags[g].eligible = ready_i[g] || flags[g].runahead;
            assign elig[g]    = flags[g].eligible;
            assign ra_cand[g] = flags[g].runahead;
            assign score_w[g] = SCORE_W'(prio_w[g]) * SCORE_W'(acc_w[g]);
        end
    endgenerate

    tsel_prio_bank #(
        .NT        (NUM_THREADS),
        .PRIO_W    (PRIO_W),
        .PRIO_INIT (PRIO_INIT),
        .IDX_W     (IDX_W)
    ) u_prio (
        .clk    (clk),
        .rst    (rst),
        .we_i   (prio_we_i),
        .sel_i  (prio_sel_i),
        .val_i  (prio_val_i),
        .prio_o (prio_w)
    );

    tsel_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step_i  (advance_i),
        .value_o (lfsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)              thresh_q <= ACC_W'(THRESH_INIT);
        else if (thresh_we_i) thresh_q <= thresh_val_i;
    end

    assign pol = policy_e'(policy_i);

    // deterministic best-score path; mask chosen by policy
    logic [NUM_THREADS-1:0] best_mask;
    logic                   best_found;
    logic [IDX_W-1:0]       best_idx;

    always_comb begin
        if (pol == POL_NORMAL_FIRST) best_mask = (|ready_i) ? ready_i : ra_cand;
        else                         best_mask = elig;
    end

    tsel_best_pick #(
        .NT      (NUM_THREADS),
        .SCORE_W (SCORE_W),
        .IDX_W   (IDX_W)
    ) u_best (
        .mask_i  (best_mask),
        .score_i (score_w),
        .rr_i    (rr_q),
        .found_o (best_found),
        .idx_o   (best_idx)
    );

    // weighted draw path
    logic [SUM_W-1:0] score_sum;
    logic [SUM_W-1:0] draw;
    logic [SUM_W-1:0] range_lo;
    logic             w_found;
    logic [IDX_W-1:0] w_idx;

    always_comb begin
        score_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (elig[t]) score_sum = score_sum + SUM_W'(score_w[t]);
        end
        draw = SUM_W'((PROD_W'(lfsr_q) * PROD_W'(score_sum)) >> LFSR_W);
        range_lo = '0;
        w_found  = 1'b0;
        w_idx    = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (elig[t]) begin
                if (!w_found && draw < range_lo + SUM_W'(score_w[t])) begin
                    w_found = 1'b1;
                    w_idx   = IDX_W'(t);
                end
                range_lo = range_lo + SUM_W'(score_w[t]);
            end
        end
    end

    // final choice
    logic             sel_found;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        if (pol == POL_WEIGHTED && score_sum != '0) begin
            sel_found = w_found;
            sel_idx   = w_idx;
        end else begin
            sel_found = best_found;
            sel_idx   = best_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o     <= '0;
            grant_idx_o <= '0;
            ra_permit_o <= 1'b0;
            rr_q        <= '0;
        end else if (advance_i) begin
            if (sel_found) begin
                grant_o     <= NUM_THREADS'(1) << sel_idx;
                grant_idx_o <= sel_idx;
                ra_permit_o <= ra_cand[sel_idx];
                rr_q        <= IDX_W'((int'(sel_idx) + 1) % NUM_THREADS);
            end else begin
                grant_o     <= '0;
                grant_idx_o <= '0;
                ra_permit_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
    parameter int NT    = 4,
    parameter int ACC_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    advance_i,
    input logic [NT-1:0]           elig_i,
    input logic [NT-1:0]           grant_i,
    input logic [$clog2(NT)-1:0]   gidx_i,
    input logic                    permit_i,
    input logic [NT-1:0][ACC_W-1:0] acc_i,
    input logic [NT-1:0]           used_i,
    input logic [NT-1:0]           wasted_i
);
    // R3
    no_elig_zero_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (advance_i && elig_i == '0) |=> (grant_i == '0 && !permit_i));

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_i));

    // R5
    idx_agrees_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_i != '0) |-> grant_i[gidx_i]);

    // R4
    permit_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        permit_i |-> (grant_i != '0));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !advance_i |=> ($stable(grant_i) && $stable(gidx_i) && $stable(permit_i)));

    generate
        for (genvar g = 0; g < NT; g++) begin : g_acc
            // R2
            acc_top_sat_chk: assert property (@(posedge clk) disable iff (rst)
                (acc_i[g] == '1 && used_i[g] && !wasted_i[g]) |=> acc_i[g] == '1);
            // R2
            acc_floor_sat_chk: assert property (@(posedge clk) disable iff (rst)
                (acc_i[g] == '0 && wasted_i[g] && !used_i[g]) |=> acc_i[g] == '0);
        end
    endgenerate
endmodule

bind thread_selector tsel_checker #(
    .NT    (NUM_THREADS),
    .ACC_W (ACC_W)
) u_tsel_chk (
    .clk       (clk),
    .rst       (rst),
    .advance_i (advance_i),
    .elig_i    (elig),
    .grant_i   (grant_o),
    .gidx_i    (grant_idx_o),
    .permit_i  (ra_permit_o),
    .acc_i     (acc_w),
    .used_i    (pf_used_i),
    .wasted_i  (pf_wasted_i)
);

// File: tb/thread_selector_test.sv
`timescale 1ns/1ps
module thread_selector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       advance = 1'b0;
    logic [1:0] policy = 2'd0;
    logic [3:0] ready = '0, stalled = '0, used = '0, wasted = '0;
    logic       prio_we = 1'b0;
    logic [1:0] prio_sel = '0;
    logic [2:0] prio_val = '0;
    logic       thresh_we = 1'b0;
    logic [7:0] thresh_val = '0;
    logic [3:0] grant;
    logic [1:0] gidx;
    logic       permit;

    always #2 clk = ~clk;

    thread_selector uut (
        .clk(clk), .rst(rst), .advance_i(advance), .policy_i(policy),
        .ready_i(ready), .stalled_i(stalled), .pf_used_i(used), .pf_wasted_i(wasted),
        .prio_we_i(prio_we), .prio_sel_i(prio_sel), .prio_val_i(prio_val),
        .thresh_we_i(thresh_we), .thresh_val_i(thresh_val),
        .grant_o(grant), .grant_idx_o(gidx), .ra_permit_o(permit)
    );

    int    total = 0, bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // reference state
    int m_acc[4], m_prio[4], m_thr, m_rr, m_lfsr;
    logic [3:0] e_grant;
    int  e_idx;
    bit  e_permit;
    bit  b_mask[4];
    int  b_score[4];

    function automatic int best_pick();
        int top = -1;
        for (int t = 0; t < 4; t++) if (b_mask[t] && b_score[t] > top) top = b_score[t];
        if (top < 0) return -1;
        for (int o = 0; o < 4; o++) begin
            int t = (m_rr + o) % 4;
            if (b_mask[t] && b_score[t] == top) return t;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 4; t++) begin m_acc[t] = 128; m_prio[t] = 1; end
        m_thr = 128; m_rr = 0; m_lfsr = 16'hACE1;
        e_grant = '0; e_idx = 0; e_permit = 0;
    endtask

    task automatic model_edge();
        bit el[4], rc[4];
        int sum = 0, win = -1;
        bit any_ready = (ready != 0);
        for (int t = 0; t < 4; t++) begin
            b_score[t] = m_prio[t] * m_acc[t];
            rc[t] = stalled[t] && !ready[t] && (m_acc[t] >= m_thr);
            el[t] = ready[t] || rc[t];
            if (el[t]) sum += b_score[t];
        end
        if (policy == 2'd2) begin
            for (int t = 0; t < 4; t++) b_mask[t] = any_ready ? ready[t] : rc[t];
            win = best_pick();
        end else if (policy == 2'd1 && sum > 0) begin
            longint d = (longint'(m_lfsr) * sum) / 65536;
            int run = 0;
            for (int t = 0; t < 4; t++) begin
                if (el[t] && win < 0) begin
                    run += b_score[t];
                    if (d < run) win = t;
                end
            end
        end else begin
            for (int t = 0; t < 4; t++) b_mask[t] = el[t];
            win = best_pick();
        end
        if (advance) begin
            if (win >= 0) begin
                e_grant = 4'(1 << win); e_idx = win; e_permit = rc[win];
                m_rr = (win + 1) % 4;
            end else begin
                e_grant = '0; e_idx = 0; e_permit = 0;
            end
            m_lfsr = ((m_lfsr << 1) & 16'hFFFF) |
                     (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
        end
        for (int t = 0; t < 4; t++) begin
            if (used[t] && !wasted[t] && m_acc[t] < 255) m_acc[t]++;
            else if (wasted[t] && !used[t] && m_acc[t] > 0) m_acc[t]--;
        end
        if (prio_we) m_prio[prio_sel] = prio_val;
        if (thresh_we) m_thr = thresh_val;
    endtask

    task automatic compare();
        total++;
        if (grant !== e_grant || int'(gidx) != e_idx || permit !== e_permit) begin
            bad++;
            $display("FAIL %s grant=%b/%b idx=%0d/%0d permit=%b/%b (actual/expected)",
                     cur_req, grant, e_grant, gidx, e_idx, permit, e_permit);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic quiet();
        used = '0; wasted = '0; prio_we = 0; thresh_we = 0;
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1 reset";
        compare();

        // R3: nothing eligible
        cur_req = "R3 empty";
        advance = 1; ready = '0; stalled = '0;
        tick();

        // R5/R6 equal scores rotate
        cur_req = "R5/R6 tie rotation";
        ready = 4'b1111;
        repeat (9) tick();

        // R11 priority write lifts thread 2
        cur_req = "R11 prio write";
        prio_we = 1; prio_sel = 2; prio_val = 3'd5;
        tick();
        quiet();
        repeat (3) tick();

        // R2 saturation both ways
        cur_req = "R2 saturation";
        used = 4'b0001; wasted = 4'b0010;
        repeat (140) tick();
        used = 4'b0011; wasted = 4'b0011;
        repeat (3) tick();
        quiet();

        // R4 runahead permit
        cur_req = "R4 permit";
        ready = '0; stalled = 4'b1111;
        repeat (3) tick();
        cur_req = "R11 threshold";
        thresh_we = 1; thresh_val = 8'd200;
        tick();
        quiet();
        repeat (3) tick();

        // R3 no candidate above threshold
        cur_req = "R3 below threshold";
        stalled = 4'b1110;
        repeat (2) tick();

        // R7/R8 weighted draw
        cur_req = "R7/R8 weighted";
        policy = 2'd1;
        thresh_we = 1; thresh_val = 8'd100; tick(); quiet();
        for (int i = 0; i < 400; i++) begin
            ready = 4'($urandom); stalled = 4'($urandom);
            tick();
        end

        // R9 ready first
        cur_req = "R9 ready first";
        policy = 2'd2;
        for (int i = 0; i < 400; i++) begin
            ready = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000;
            stalled = 4'($urandom);
            tick();
        end

        // R10 advance gating
        cur_req = "R10 hold";
        for (int i = 0; i < 300; i++) begin
            advance = ($urandom % 2) == 0;
            policy = 2'($urandom);
            ready = 4'($urandom); stalled = 4'($urandom);
            tick();
        end

        // mixed
        cur_req = "R2/R5/R7/R9/R11 mixed";
        for (int i = 0; i < 2500; i++) begin
            advance = ($urandom % 5) != 0;
            policy = 2'($urandom);
            ready = ($urandom % 2) ? 4'($urandom) : 4'b0000;
            stalled = 4'($urandom);
            used = 4'($urandom); wasted = 4'($urandom);
            prio_we = ($urandom % 6) == 0;
            prio_sel = 2'($urandom); prio_val = 3'($urandom);
            thresh_we = ($urandom % 40) == 0;
            thresh_val = 8'($urandom);
            tick();
        end
        quiet();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule